// File: doc/BRIEF.md
# Two-Wire Byte Memory Slave with Region Write Lock

This block is a byte-wide memory that sits on a two-wire serial bus as a slave. It answers two 7-bit device addresses. One opens the memory array. The other opens a small bank of control registers. The bus lines are sampled by the system clock and synchronised inside the block. The block only ever pulls SDA low and never stretches SCL.

Memory transfers always carry a 16-bit address, high byte first. Address bits above the array depth are ignored. A pointer remembers the most recent memory location. It advances after every data byte, and wraps from the top of the array to zero. A read that skips the address phase continues from this pointer. Register transfers carry a one-byte index and keep their own index. They never touch the memory pointer.

One control register holds a two-bit lock code. The code selects how much of the low end of the array refuses writes. A data byte aimed at a locked location gets no acknowledge and is discarded. Reads are never restricted.

Top module: `wpmem_slave`

## Requirements
- R1: After reset the slave releases SDA, the memory pointer is 0 and every control register reads 0x00.
- R2: A first byte whose upper seven bits are neither the memory ID 0x50 nor the register ID 0x68 is not acknowledged. The transfer is ignored until the next START.
- R3: Memory write: the ID with bit 0 = 0, then an address high byte, an address low byte and data bytes. The slave acknowledges every byte. Only the low log2(DEPTH) address bits are used. Each accepted byte is stored at the pointer, which then advances and wraps from DEPTH-1 to 0.
- R4: Memory read: the ID with bit 0 = 1. The slave returns the byte at the pointer, MSB first, and advances the pointer. It continues while the master acknowledges and stops at a master NACK.
- R5: A read that follows a STOP without any new address phase starts at the retained pointer.
- R6: Register access: ID 0x68, then a one-byte index (low 4 bits used), then data. The slave acknowledges every byte. The register bank holds 16 bytes that are plain read/write storage. The index advances per byte and wraps from 15 to 0. Reads use the index left by the last access.
- R7: The lock code sits in register index 0x0B, with bit 3 = WP1 and bit 2 = WP0. Code 00 locks nothing. Code 01 locks addresses below DEPTH/4. Code 10 locks addresses below DEPTH/2. Code 11 locks the whole array.
- R8: A data byte addressed to a locked location is not acknowledged. Memory is left unchanged and the pointer does not advance. Every byte of a sequential write is checked separately.
- R9: The lock code never affects memory reads.
- R10: Register accesses leave the memory pointer unchanged.
- R11: The slave changes its SDA drive only while SCL is low.
- R12: There is no busy period: a new transfer directly after a write's STOP is served normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_drive_low | output | 1 | 1 pulls SDA low (open-drain enable) |

## Verification
The checker assumes a single well-behaved master. SCL and SDA are held for several system clocks per phase. SDA changes only while SCL is low, except at START and STOP. The master never raises SDA while the slave is pulling it low. Under these assumptions, the SDA-timing property and the rule that only unlocked writes are committed are meaningful. The bench master spaces every line change five clocks apart. It releases SDA before the slave's acknowledge window and frames each random operation with START and STOP. So the random mix of writes, reads, index accesses and lock changes stays inside these assumptions.

// File: rtl/wpmem_pkg.sv
package wpmem_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK
    } bus_state_t;

    typedef enum logic [2:0] {
        PH_DEV,
        PH_AHI,
        PH_ALO,
        PH_MDATA,
        PH_RIDX,
        PH_RDATA
    } rx_phase_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } bus_evt_t;

    localparam int unsigned LOCK_REG_IDX = 11;
    localparam int unsigned LOCK_LSB     = 2;

    // 1 when a write to addr must be refused under lock code
    function automatic logic region_locked(input logic [1:0] code,
                                           input int unsigned addr,
                                           input int unsigned depth);
        logic res;
        case (code)
            2'b00:   res = 1'b0;
            2'b01:   res = (addr < depth / 4);
            2'b10:   res = (addr < depth / 2);
            default: res = 1'b1;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/wpmem_bus_sync.sv
module wpmem_bus_sync
    import wpmem_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt
);
    logic [2:0] scl_sh;
    logic [2:0] sda_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= '1;
            sda_sh <= '1;
        end else begin
            scl_sh <= {scl_sh[1:0], scl_i};
            sda_sh <= {sda_sh[1:0], sda_i};
        end
    end

    always_comb begin
        evt.scl_rise = scl_sh[1] & ~scl_sh[2];
        evt.scl_fall = ~scl_sh[1] & scl_sh[2];
        evt.start    = scl_sh[1] & scl_sh[2] & ~sda_sh[1] & sda_sh[2];
        evt.stop     = scl_sh[1] & scl_sh[2] & sda_sh[1] & ~sda_sh[2];
        evt.sda      = sda_sh[1];
    end
endmodule

// File: rtl/wpmem_array.sv
module wpmem_array #(
    parameter int DEPTH = 2048,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/wpmem_regs.sv
module wpmem_regs
    import wpmem_pkg::*;
#(
    parameter int NREG = 16,
    localparam int IW = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [7:0]    wdata,
    input  logic [IW-1:0] ridx,
    output logic [7:0]    rdata,
    output logic [1:0]    lock_code
);
    logic [7:0] bank [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) bank[i] <= 8'h00;
        end else if (we) begin
            bank[widx] <= wdata;
        end
    end

    assign rdata     = bank[ridx];
    assign lock_code = bank[LOCK_REG_IDX][LOCK_LSB +: 2];
endmodule

// File: rtl/wpmem_slave.sv
module wpmem_slave
    import wpmem_pkg::*;
#(
    parameter int         DEPTH  = 2048,
    parameter int         NREG   = 16,
    parameter logic [6:0] MEM_ID = 7'h50,
    parameter logic [6:0] REG_ID = 7'h68
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_drive_low
);
    localparam int AW = $clog2(DEPTH);
    localparam int IW = $clog2(NREG);

    bus_evt_t   evt;
    bus_state_t state;
    rx_phase_t  phase;
    logic [3:0]    cnt;
    logic [7:0]    shreg;
    logic [7:0]    txb;
    logic [7:0]    addr_hi;
    logic [AW-1:0] mem_ptr;
    logic [IW-1:0] reg_ptr;
    logic          is_read;
    logic          tgt_reg;
    logic          mack_ok;
    logic          sda_oe;

    logic [15:0]   full_addr;
    logic [7:0]    mem_rdata;
    logic [7:0]    reg_rdata;
    logic [7:0]    tx_src;
    logic [1:0]    lock_code;
    logic          hit_mem, hit_reg, locked, byte_done, ack_now;
    logic          mem_we, reg_we, bus_idle;

    wpmem_bus_sync u_sync (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .evt(evt)
    );

    wpmem_array #(.DEPTH(DEPTH)) u_array (
        .clk(clk), .we(mem_we), .waddr(mem_ptr), .wdata(shreg),
        .raddr(mem_ptr), .rdata(mem_rdata)
    );

    wpmem_regs #(.NREG(NREG)) u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .widx(reg_ptr), .wdata(shreg),
        .ridx(reg_ptr), .rdata(reg_rdata), .lock_code(lock_code)
    );

    always_comb begin
        full_addr = {addr_hi, shreg};
        hit_mem   = (shreg[7:1] == MEM_ID);
        hit_reg   = (shreg[7:1] == REG_ID);
        locked    = region_locked(lock_code, 32'(mem_ptr), DEPTH);
        byte_done = (state == ST_RX) && evt.scl_fall && (cnt == 4'd8);
        tx_src    = tgt_reg ? reg_rdata : mem_rdata;
        case (phase)
            PH_DEV:   ack_now = hit_mem | hit_reg;
            PH_MDATA: ack_now = ~locked;
            default:  ack_now = 1'b1;
        endcase
        mem_we   = byte_done && (phase == PH_MDATA) && !locked;
        reg_we   = byte_done && (phase == PH_RDATA);
        bus_idle = (state == ST_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            phase   <= PH_DEV;
            cnt     <= '0;
            shreg   <= '0;
            txb     <= '0;
            addr_hi <= '0;
            mem_ptr <= '0;
            reg_ptr <= '0;
            is_read <= 1'b0;
            tgt_reg <= 1'b0;
            mack_ok <= 1'b0;
            sda_oe  <= 1'b0;
        end else if (evt.start) begin
            state   <= ST_RX;
            phase   <= PH_DEV;
            cnt     <= '0;
            is_read <= 1'b0;
            sda_oe  <= 1'b0;
        end else if (evt.stop) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
        end else begin
            case (state)
                ST_RX: begin
                    if (evt.scl_rise && cnt < 4'd8) begin
                        shreg <= {shreg[6:0], evt.sda};
                        cnt   <= cnt + 4'd1;
                    end
                    if (byte_done) begin
                        if (ack_now) begin
                            sda_oe <= 1'b1;
                            state  <= ST_ACK;
                            case (phase)
                                PH_DEV: begin
                                    tgt_reg <= hit_reg;
                                    is_read <= shreg[0];
                                    phase   <= hit_reg ? PH_RIDX : PH_AHI;
                                end
                                PH_AHI: begin
                                    addr_hi <= shreg;
                                    phase   <= PH_ALO;
                                end
                                PH_ALO: begin
                                    mem_ptr <= full_addr[AW-1:0];
                                    phase   <= PH_MDATA;
                                end
                                PH_MDATA: mem_ptr <= mem_ptr + 1'b1;
                                PH_RIDX: begin
                                    reg_ptr <= shreg[IW-1:0];
                                    phase   <= PH_RDATA;
                                end
                                default:  reg_ptr <= reg_ptr + 1'b1;
                            endcase
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_ACK: begin
                    if (evt.scl_fall) begin
                        cnt <= '0;
                        if (is_read) begin
                            txb    <= tx_src;
                            sda_oe <= ~tx_src[7];
                            cnt    <= 4'd1;
                            state  <= ST_TX;
                            if (tgt_reg) reg_ptr <= reg_ptr + 1'b1;
                            else         mem_ptr <= mem_ptr + 1'b1;
                        end else begin
                            sda_oe <= 1'b0;
                            state  <= ST_RX;
                        end
                    end
                end
                ST_TX: begin
                    if (evt.scl_fall) begin
                        if (cnt == 4'd8) begin
                            sda_oe <= 1'b0;
                            state  <= ST_MACK;
                        end else begin
                            sda_oe <= ~txb[6];
                            txb    <= {txb[6:0], 1'b0};
                            cnt    <= cnt + 4'd1;
                        end
                    end
                end
                ST_MACK: begin
                    if (evt.scl_rise) mack_ok <= ~evt.sda;
                    if (evt.scl_fall) begin
                        if (mack_ok) begin
                            txb    <= tx_src;
                            sda_oe <= ~tx_src[7];
                            cnt    <= 4'd1;
                            state  <= ST_TX;
                            if (tgt_reg) reg_ptr <= reg_ptr + 1'b1;
                            else         mem_ptr <= mem_ptr + 1'b1;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign sda_drive_low = sda_oe;
endmodule

// File: rtl/wpmem_slave_chk.sv
module wpmem_slave_chk #(
    parameter int DEPTH = 2048,
    localparam int AW = $clog2(DEPTH)
) (
    input logic          clk,
    input logic          rst,
    input logic          scl_i,
    input logic          sda_drive_low,
    input logic          bus_idle,
    input logic          mem_we,
    input logic          reg_we,
    input logic [AW-1:0] mem_ptr,
    input logic [1:0]    lock_code
);
    localparam logic [AW-1:0] QUARTER = AW'(DEPTH / 4);
    localparam logic [AW-1:0] HALF    = AW'(DEPTH / 2);

    AST_WRITE_UNLOCKED: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> ((lock_code == 2'b00) ||
                    (lock_code == 2'b01 && mem_ptr >= QUARTER) ||
                    (lock_code == 2'b10 && mem_ptr >= HALF)));  // R8

    AST_PTR_KEPT_ON_REG: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> $stable(mem_ptr));  // R10

    AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_drive_low) |-> !scl_i);  // R11

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        bus_idle |-> !sda_drive_low);  // R2

    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_we, reg_we}));  // R6
endmodule

bind wpmem_slave wpmem_slave_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk),
    .rst(rst),
    .scl_i(scl_i),
    .sda_drive_low(sda_drive_low),
    .bus_idle(bus_idle),
    .mem_we(mem_we),
    .reg_we(reg_we),
    .mem_ptr(mem_ptr),
    .lock_code(lock_code)
);

// File: tb/wpmem_slave_tb.sv
module wpmem_slave_tb;
    localparam int DEPTH = 2048;
    localparam int Q     = 5;
    localparam int LIMIT = 190000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_drive_low;
    logic sda_bus;

    assign sda_bus = m_sda & ~sda_drive_low;
    always #5 clk = ~clk;

    wpmem_slave #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_bus),
        .sda_drive_low(sda_drive_low)
    );

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int sda_viol = 0;
    bit done = 0;
    logic last_drv = 1'b0;

    logic [7:0] ref_mem [DEPTH];
    bit         known   [DEPTH];
    logic [7:0] ref_reg [16];
    int ref_ptr = 0;
    int ref_ridx = 0;

    function automatic bit exp_locked(int addr, logic [1:0] code);
        if (code == 2'b01) return addr < DEPTH / 4;
        if (code == 2'b10) return addr < DEPTH / 2;
        return code == 2'b11;
    endfunction

    function automatic logic [1:0] cur_code();
        return ref_reg[11][3:2];
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (cyc > LIMIT && !done) begin
            done = 1;
            failures++;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // r11_ monitor: SDA drive may only move while SCL is low
    always @(posedge clk) begin
        #1;
        if (!rst && sda_drive_low !== last_drv && m_scl) sda_viol++;
        last_drv = sda_drive_low;
    end

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic i2c_start();
        m_sda = 1; wq(); m_scl = 1; wq(); m_sda = 0; wq(); m_scl = 0; wq();
    endtask

    task automatic i2c_stop();
        m_sda = 0; wq(); m_scl = 1; wq(); m_sda = 1; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wq(); m_scl = 1; wq(); wq(); m_scl = 0;
        end
        wq(); m_sda = 1; wq(); m_scl = 1; wq();
        ack = ~sda_bus;
        wq(); m_scl = 0; wq();
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        m_sda = 1;
        for (int i = 7; i >= 0; i--) begin
            wq(); m_scl = 1; wq(); b[i] = sda_bus; wq(); m_scl = 0;
        end
        wq(); m_sda = give_ack ? 1'b0 : 1'b1; wq(); m_scl = 1; wq(); wq();
        m_scl = 0; wq(); m_sda = 1;
    endtask

    task automatic mem_set_ptr(input int addr, input logic [15:0] hi_junk);
        bit a;
        logic [15:0] w;
        w = 16'(addr) | hi_junk;
        i2c_start();
        send_byte(8'hA0, a); check(a, "R2", "mem id ack", a, 1);
        send_byte(w[15:8], a); check(a, "R3", "addr hi ack", a, 1);
        send_byte(w[7:0], a);  check(a, "R3", "addr lo ack", a, 1);
        i2c_stop();
        ref_ptr = addr;
    endtask

    task automatic mem_write(input int addr, input int n, input logic [15:0] hi_junk,
                             input string req);
        bit a;
        bit exp;
        logic [7:0] d;
        logic [15:0] w;
        w = 16'(addr) | hi_junk;
        i2c_start();
        send_byte(8'hA0, a); check(a, "R2", "mem id ack", a, 1);
        send_byte(w[15:8], a); check(a, "R3", "addr hi ack", a, 1);
        send_byte(w[7:0], a);  check(a, "R3", "addr lo ack", a, 1);
        ref_ptr = addr;
        for (int k = 0; k < n; k++) begin
            d = 8'($urandom);
            exp = !exp_locked(ref_ptr, cur_code());
            send_byte(d, a);
            check(a == exp, exp ? req : "R8", "data ack", a, exp);
            if (!a) break;
            ref_mem[ref_ptr] = d;
            known[ref_ptr] = 1;
            ref_ptr = (ref_ptr + 1) % DEPTH;
        end
        i2c_stop();
    endtask

    task automatic mem_read_cur(input int n, input string req);
        bit a;
        logic [7:0] d;
        i2c_start();
        send_byte(8'hA1, a); check(a, "R2", "mem read id ack", a, 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k < n - 1, d);
            if (known[ref_ptr])
                check(d == ref_mem[ref_ptr], req, "read data", d, ref_mem[ref_ptr]);
            ref_ptr = (ref_ptr + 1) % DEPTH;
        end
        i2c_stop();
    endtask

    task automatic reg_write(input int idx, input logic [7:0] v0, input logic [7:0] v1,
                             input int n);
        bit a;
        i2c_start();
        send_byte(8'hD0, a); check(a, "R6", "reg id ack", a, 1);
        send_byte(8'(idx), a); check(a, "R6", "reg index ack", a, 1);
        ref_ridx = idx % 16;
        for (int k = 0; k < n; k++) begin
            send_byte(k == 0 ? v0 : v1, a); check(a, "R6", "reg data ack", a, 1);
            ref_reg[ref_ridx] = (k == 0) ? v0 : v1;
            ref_ridx = (ref_ridx + 1) % 16;
        end
        i2c_stop();
    endtask

    task automatic reg_read(input int idx, input int n, input string req);
        bit a;
        logic [7:0] d;
        i2c_start();
        send_byte(8'hD0, a); check(a, "R6", "reg id ack", a, 1);
        send_byte(8'(idx), a); check(a, "R6", "reg index ack", a, 1);
        i2c_stop();
        ref_ridx = idx % 16;
        i2c_start();
        send_byte(8'hD1, a); check(a, "R6", "reg read id ack", a, 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k < n - 1, d);
            check(d == ref_reg[ref_ridx], req, "reg data", d, ref_reg[ref_ridx]);
            ref_ridx = (ref_ridx + 1) % 16;
        end
        i2c_stop();
    endtask

    initial begin
        bit a;
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < DEPTH; i++) known[i] = 0;
        for (int i = 0; i < 16; i++) ref_reg[i] = 8'h00;
        repeat (4) @(negedge clk);
        rst = 0;
        repeat (4) @(negedge clk);

        // R1: released line, registers cleared
        check(sda_drive_low == 1'b0, "R1", "sda after reset", sda_drive_low, 0);
        reg_read(11, 2, "R1");

        // R2: foreign ID refused
        i2c_start();
        send_byte(8'hA2, a); check(!a, "R2", "foreign id nack", a, 0);
        i2c_stop();

        // R3/R4: wrap at top, upper address bits ignored
        mem_write(DEPTH - 2, 4, 16'hF800, "R3");
        mem_set_ptr(DEPTH - 2, 16'h0000);
        mem_read_cur(4, "R4");

        // R5/R10/R12: pointer kept across register traffic
        mem_write(100, 4, 16'h0000, "R12");
        mem_set_ptr(100, 16'h0000);
        mem_read_cur(2, "R4");
        reg_write(3, 8'h5A, 8'h00, 1);
        reg_read(3, 1, "R6");
        mem_read_cur(2, "R10");
        mem_read_cur(1, "R5");

        // R6: index wrap
        reg_write(15, 8'hC3, 8'h3C, 2);
        reg_read(15, 2, "R6");

        // seed bytes at the region edges while unlocked
        mem_write(DEPTH / 4 - 1, 2, 16'h0000, "R3");
        mem_write(DEPTH / 2 - 1, 2, 16'h0000, "R3");
        mem_write(DEPTH - 1, 1, 16'h0000, "R3");

        // R7/R8: code 01 quarter
        reg_write(11, 8'h04, 8'h00, 1);
        mem_write(DEPTH / 4 - 1, 1, 16'h0000, "R7");
        mem_read_cur(1, "R8");          // pointer not advanced, byte unchanged
        mem_write(DEPTH / 4, 1, 16'h0000, "R7");
        mem_write(DEPTH - 1, 2, 16'h0000, "R8");   // second byte wraps into lock
        mem_set_ptr(0, 16'h0000);
        mem_read_cur(2, "R9");

        // code 10 half
        reg_write(11, 8'h08, 8'h00, 1);
        mem_write(DEPTH / 2 - 1, 1, 16'h0000, "R7");
        mem_write(DEPTH / 2, 1, 16'h0000, "R7");
        // code 11 whole
        reg_write(11, 8'h0C, 8'h00, 1);
        mem_write(DEPTH - 1, 1, 16'h0000, "R7");
        mem_set_ptr(DEPTH / 4 - 1, 16'h0000);
        mem_read_cur(3, "R9");

        // random mix
        for (int it = 0; it < 40; it++) begin
            int op;
            int addr;
            op = int'($urandom_range(0, 3));
            addr = int'($urandom_range(0, DEPTH - 1));
            case (op)
                0: mem_write(addr, int'($urandom_range(1, 3)), 16'h0000, "R3");
                1: begin
                    mem_set_ptr(addr, 16'h0000);
                    mem_read_cur(int'($urandom_range(1, 3)), "R4");
                end
                2: reg_write(11, 8'($urandom), 8'h00, 1);
                default: mem_read_cur(2, "R5");
            endcase
        end

        check(sda_viol == 0, "R11", "sda moved while scl high", sda_viol, 0);

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule